// File: doc/BRIEF.md
# Shared-Multiplier Complex Norm-Square Accumulator

This block computes the squared magnitude of a complex column vector of `LEN` entries (default 8). The entries arrive one per clock. Only two real multipliers are used, and they are shared over time. One squares the real part and the other squares the imaginary part. The two squares are added into a running sum. A start flag on the first entry clears the sum, and an end flag on the last entry hands the total to the output with a one-cycle valid pulse. At one entry per clock a new vector can follow straight after the previous one, so results leave at the input rate with no buffering.

Each slot carries an activity bit. When it is low, the entry is known to be zero, the multipliers are gated off and the entry adds nothing. A combinational strobe reports every clock in which the multipliers are not in use, so that neighbouring logic can borrow them. A triangular lower half produces a fixed pattern of such slots. The result register is wide enough that even full-scale negative inputs cannot overflow it.

Top module: `cnorm_accum`

## Requirements
- R1: While `rst_n` is low, and directly after it, `out_valid` is 0 and `out_norm` is 0.
- R2: `out_norm` equals the sum of re*re + im*im over the active entries from the start-flagged entry to the end-flagged entry. The entries are two's-complement `W`-bit values, and the result is an unsigned `2*W+1+clog2(LEN)`-bit value.
- R3: `out_valid` is high for exactly one cycle, at the second rising edge after the edge that samples an entry with `in_valid` and `in_last` both high. At no other time is it high.
- R4: An entry with `in_first` high starts a new sum. Earlier entries that were not closed by a last flag contribute nothing.
- R5: An entry with `in_active` low contributes zero, whatever its data.
- R6: `idle_slot` is high in exactly those cycles in which `in_valid` and `in_active` are not both high.
- R7: Cycles with `in_valid` low neither add to the sum nor clear it. A vector may have gaps.
- R8: Vectors sent back to back, one entry per clock, give one result every `LEN` clocks.
- R9: `LEN` entries with both parts at -2^(W-1) give exactly LEN*2^(2W-1), with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Entry present this cycle |
| in_first | input | 1 | Entry is the first of a vector |
| in_last | input | 1 | Entry is the last of a vector |
| in_active | input | 1 | Entry may be nonzero; low gates the multipliers |
| in_re | input | W | Real part, two's complement |
| in_im | input | W | Imaginary part, two's complement |
| out_valid | output | 1 | One-cycle result strobe |
| out_norm | output | 2*W+1+clog2(LEN) | Unsigned norm square |
| idle_slot | output | 1 | Multipliers free this cycle |

## Verification
The bench aims at the corner cases where sharing and flag handling break. Full-scale negative entries would wrap a result register that is too narrow, and would give the wrong sign if the squares were taken as signed. Inactive slots carry nonzero data, so a design that fails to gate them would add stray energy. Vectors that follow each other directly, and a vector left open and then restarted by a first flag, catch a sum that is not cleared or is cleared one cycle late. Gaps in `in_valid` in the middle of a vector catch a sum that drifts or resets while no entry is present.

// File: rtl/cnorm_accum.sv
module cnorm_accum #(
  parameter int W   = 14,
  parameter int LEN = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  input  logic                                in_first,
  input  logic                                in_last,
  input  logic                                in_active,
  input  logic signed [W-1:0]                 in_re,
  input  logic signed [W-1:0]                 in_im,
  output logic                                out_valid,
  output logic [2*W+$clog2(LEN):0]            out_norm,
  output logic                                idle_slot
);
  localparam int ACC_W = 2*W + 1 + $clog2(LEN);
  localparam int SQ_W  = 2*W - 1;
  localparam logic [ACC_W-1:0] NORM_MAX = ACC_W'(LEN) << (2*W - 1);

  logic signed [2*W-1:0] sq_re, sq_im;
  logic [SQ_W-1:0]       p_re, p_im;
  logic                  s1_valid, s1_first, s1_last;
  logic [ACC_W-1:0]      acc, sum_next;
  logic                  mul_en;

  assign mul_en    = in_valid & in_active;
  assign idle_slot = ~mul_en;
  assign sq_re     = in_re * in_re;
  assign sq_im     = in_im * in_im;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_re     <= '0;
      p_im     <= '0;
      s1_valid <= 1'b0;
      s1_first <= 1'b0;
      s1_last  <= 1'b0;
    end else begin
      p_re     <= mul_en ? sq_re[SQ_W-1:0] : '0;
      p_im     <= mul_en ? sq_im[SQ_W-1:0] : '0;
      s1_valid <= in_valid;
      s1_first <= in_valid & in_first;
      s1_last  <= in_valid & in_last;
    end
  end

  assign sum_next = (s1_first ? '0 : acc) + ACC_W'(p_re) + ACC_W'(p_im);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc       <= '0;
      out_valid <= 1'b0;
      out_norm  <= '0;
    end else begin
      out_valid <= s1_valid & s1_last;
      if (s1_valid) acc <= sum_next;
      if (s1_valid && s1_last) out_norm <= sum_next;
    end
  end

  assert_result_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_last |-> ##2 out_valid);

  assert_valid_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(s1_valid && s1_last));

  assert_gated_product_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_active) |=> (p_re == '0 && p_im == '0));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_norm <= NORM_MAX);
endmodule

// File: tb/cnorm_accum_tb_top.sv
module cnorm_accum_tb_top;
  localparam int W = 14;
  localparam int LEN = 8;
  localparam int ACC_W = 2*W + 1 + $clog2(LEN);
  localparam longint HALF = longint'(1) << (W-1);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_first = 0, in_last = 0, in_active = 0;
  logic signed [W-1:0] in_re = '0, in_im = '0;
  logic out_valid, idle_slot;
  logic [ACC_W-1:0] out_norm;

  int tests = 0, fails = 0, cyc = 0;
  string phase = "R1";
  longint model_sum = 0;
  longint q_val[$];
  int q_due[$];

  cnorm_accum #(.W(W), .LEN(LEN)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_active(in_active), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_norm(out_norm), .idle_slot(idle_slot));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL watchdog: act=%0d exp<=100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(bit ok, string req, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s @%0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic compare_outputs();
    if (q_due.size() > 0 && q_due[0] == cyc) begin
      check(out_valid == 1'b1, {phase, " R3 valid"}, out_valid, 1);
      check(out_norm == ACC_W'(q_val[0]), {phase, " R2 value"}, out_norm, q_val[0]);
      void'(q_due.pop_front()); void'(q_val.pop_front());
    end else begin
      check(out_valid == 1'b0, {phase, " R3 no pulse"}, out_valid, 0);
    end
  endtask

  task automatic step(bit v, bit f, bit l, bit a, longint re, longint im);
    @(negedge clk);
    compare_outputs();
    in_valid = v; in_first = f; in_last = l; in_active = a;
    in_re = W'(re); in_im = W'(im);
    if (v) begin
      if (f) model_sum = 0;
      if (a) model_sum += re*re + im*im;
      if (l) begin q_val.push_back(model_sum); q_due.push_back(cyc + 2); end
    end
    #1 check(idle_slot == !(v && a), {phase, " R6 idle"}, idle_slot, !(v && a));
  endtask

  function automatic longint rnd();
    return longint'($urandom_range(0, (1 << W) - 1)) - HALF;
  endfunction

  task automatic send_vec(bit [LEN-1:0] mask, bit full);
    for (int i = 0; i < LEN; i++)
      step(1, i == 0, i == LEN-1, mask[i], full ? -HALF : rnd(), full ? -HALF : rnd());
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 0, "R1 reset valid", out_valid, 0);
    check(out_norm == 0, "R1 reset norm", out_norm, 0);
    rst_n = 1;
    step(0, 0, 0, 0, 0, 0);
    check(out_valid == 0 && out_norm == 0, "R1 after reset", out_norm, 0);

    phase = "R2"; send_vec('1, 0);
    repeat (4) step(0, 0, 0, 0, rnd(), rnd());

    phase = "R8"; for (int k = 0; k < 4; k++) send_vec('1, 0);
    repeat (3) step(0, 0, 0, 0, 0, 0);

    phase = "R5"; send_vec(8'b1111_1000, 0);
    send_vec(8'b0101_0101, 0);
    repeat (3) step(0, 0, 0, 0, 0, 0);

    phase = "R7";
    for (int i = 0; i < LEN; i++) begin
      step(1, i == 0, i == LEN-1, 1, rnd(), rnd());
      if (i == 2 || i == 5) begin
        step(0, 1, 0, 1, rnd(), rnd());
        step(0, 0, 1, 1, rnd(), rnd());
      end
    end
    repeat (3) step(0, 0, 0, 0, 0, 0);

    phase = "R4";
    for (int i = 0; i < 5; i++) step(1, i == 0, 0, 1, rnd(), rnd());
    send_vec('1, 0);
    step(1, 1, 1, 1, rnd(), rnd());
    repeat (3) step(0, 0, 0, 0, 0, 0);

    phase = "R9"; send_vec('1, 1);
    send_vec('1, 1);
    repeat (4) step(0, 0, 0, 0, 0, 0);

    check(q_due.size() == 0, "R3 all results seen", q_due.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule